// File: doc/BRIEF.md
# Own Self-ID Quadlet Generator

This block assembles the local node's own self-ID quadlet for a serial-bus link layer. After a start pulse it fetches six PHY registers (addresses 1 to 6, in that order) over a plain read-strobe/status-word handshake. It then packs their fields and the node's physical ID into one 32-bit word. A read finishes when the PHY's status word reports the requested address. If a read never finishes, the sequence gives up after a bounded number of polls and reports an error.

The link layer pulses `start_i` when it needs its own quadlet, for example after a bus reset. It waits for `done_o` and then reads `selfid_o`, or sees `err_o` and keeps its previous quadlet. The physical ID is captured when the start pulse is accepted. Writes to the PHY, multi-packet self-IDs and the other self-ID packet forms are not handled here.

Top module: `own_selfid_gen`

## Requirements
- R1: Reset state. While `rst_ni` is low and after its release, `busy_o`, `done_o`, `err_o` and `phy_rd_o` are 0, and `selfid_o` is 0.
- R2: Read order. A start accepted while idle yields a one-cycle `phy_rd_o` on the next cycle with `phy_addr_o`=1. Each following register is requested one cycle after the previous read completes, addresses going up by one to 6.
- R3: Completion. A read completes on the first sampled status word whose bits 27:24 equal the requested address, and the register value is taken from bits 23:16 of that word. Words carrying any other address are ignored. The first sample is taken one cycle after the strobe.
- R4: Timeout. If `MAX_POLLS` consecutive samples fail to match, `done_o` rises on the next cycle with `err_o`=1. No further reads are issued, and `selfid_o` keeps its previous value. A match on the last permitted sample still counts as success.
- R5: Frame. On success `selfid_o` is 0x80400000 ORed with the captured physical ID in bits 29:24. The physical ID is sampled from `phy_id_i` when start is accepted.
- R6: Gap count and speed. Register 1 bits 5:0 appear in bits 21:16, and register 2 bits 7:6 appear in bits 15:14.
- R7: Flags. Register 6 bit 0 (contender) appears in bit 11, and register 6 bit 4 (initiated reset) appears in bit 1. All other bits not named by R5 to R9 are 0.
- R8: Port code. The field for port i sits at bits (7-2i):(6-2i) and is built from register 3+i. It is 01 when that register's bit 2 is 0, 11 when bits 2 and 3 are both 1, and 10 when bit 2 is 1 and bit 3 is 0.
- R9: Port count. The port count is register 2 bits 4:0, clamped to 3. Fields of ports at or beyond the count are 00.
- R10: Handshake. `done_o` is a one-cycle pulse, and `busy_o` is 1 from the cycle after start through the done cycle. `start_i` is ignored while busy, and `selfid_o` changes only in a successful done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a build; ignored while busy |
| phy_id_i | input | 6 | Node physical ID, sampled at start |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | With done: a PHY read timed out |
| selfid_o | output | 32 | Last successfully built self-ID quadlet |
| phy_rd_o | output | 1 | PHY register read strobe |
| phy_addr_o | output | 4 | PHY register address for the strobe |
| phy_status_i | input | 32 | PHY status word: address 27:24, data 23:16 |

## Verification
The matching sample and the poll limit can coincide: a status word with the right address may arrive on the very sample where the poll counter expires. The bench sets a PHY latency that puts the match exactly on sample `MAX_POLLS` and expects success. It then uses one cycle more and expects the error path. Both outcomes are judged from the cycle in which a behavioural cycle-count model predicts the done pulse. A second overlap is a new start and a changed physical ID arriving while a build runs. This is judged by the unchanged done timing and an unchanged ID field.

// File: rtl/selfid_pkg.sv
package selfid_pkg;
  localparam int unsigned PHY_REG_W   = 8;
  localparam int unsigned PHY_ADDR_W  = 4;
  localparam int unsigned STAT_W      = 32;
  localparam int unsigned PHY_ID_W    = 6;
  localparam int unsigned SID_W       = 32;
  localparam int unsigned FIRST_REG   = 1;
  localparam int unsigned LAST_REG    = 6;
  localparam int unsigned NUM_REGS    = LAST_REG - FIRST_REG + 1;
  localparam int unsigned IDX_W       = $clog2(NUM_REGS);
  localparam int unsigned STAT_ADDR_LSB = 24;
  localparam int unsigned STAT_DATA_LSB = 16;
  localparam logic [SID_W-1:0] SID_BASE = 32'h8040_0000;
  localparam int unsigned FIELD_PORTS_MAX = 3;

  typedef logic [PHY_REG_W-1:0] phy_byte_t;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_REQ,
    SEQ_WAIT,
    SEQ_BUILD,
    SEQ_DONE
  } seq_state_e;
endpackage

// File: rtl/phy_read_seq.sv
module phy_read_seq
  import selfid_pkg::*;
#(
  parameter int unsigned MAX_POLLS = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [STAT_W-1:0]     phy_status_i,
  output logic                  phy_rd_o,
  output logic [PHY_ADDR_W-1:0] phy_addr_o,
  output logic                  cap_en_o,
  output logic [IDX_W-1:0]      cap_idx_o,
  output phy_byte_t             cap_data_o,
  output logic                  build_o,
  output logic                  done_o,
  output logic                  err_o,
  output logic                  busy_o
);
  localparam int unsigned POLL_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

  seq_state_e            state_q, state_d;
  logic [PHY_ADDR_W-1:0] addr_q, addr_d;
  logic [POLL_W-1:0]     poll_q, poll_d;
  logic                  err_q, err_d;
  logic                  hit;
  logic                  unused_stat_bits;

  assign hit = (phy_status_i[STAT_ADDR_LSB +: PHY_ADDR_W] == addr_q);
  assign unused_stat_bits = ^{phy_status_i[STAT_W-1:STAT_ADDR_LSB+PHY_ADDR_W],
                              phy_status_i[STAT_DATA_LSB-1:0]};

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    poll_d  = poll_q;
    err_d   = err_q;
    unique case (state_q)
      SEQ_IDLE: if (start_i) begin
        state_d = SEQ_REQ;
        addr_d  = PHY_ADDR_W'(FIRST_REG);
        err_d   = 1'b0;
      end
      SEQ_REQ: begin
        poll_d  = '0;
        state_d = SEQ_WAIT;
      end
      SEQ_WAIT: begin
        if (hit) begin
          if (addr_q == PHY_ADDR_W'(LAST_REG)) begin
            state_d = SEQ_BUILD;
          end else begin
            addr_d  = addr_q + 1'b1;
            state_d = SEQ_REQ;
          end
        end else if (poll_q == POLL_W'(MAX_POLLS - 1)) begin
          err_d   = 1'b1;
          state_d = SEQ_DONE;
        end else begin
          poll_d = poll_q + 1'b1;
        end
      end
      SEQ_BUILD: state_d = SEQ_DONE;
      SEQ_DONE:  state_d = SEQ_IDLE;
      default:   state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      addr_q  <= '0;
      poll_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      poll_q  <= poll_d;
      err_q   <= err_d;
    end
  end

  assign phy_rd_o   = (state_q == SEQ_REQ);
  assign phy_addr_o = addr_q;
  assign cap_en_o   = (state_q == SEQ_WAIT) && hit;
  assign cap_idx_o  = IDX_W'(addr_q - PHY_ADDR_W'(FIRST_REG));
  assign cap_data_o = phy_status_i[STAT_DATA_LSB +: PHY_REG_W];
  assign build_o    = (state_q == SEQ_BUILD);
  assign done_o     = (state_q == SEQ_DONE);
  assign err_o      = done_o && err_q;
  assign busy_o     = (state_q != SEQ_IDLE);
endmodule

// File: rtl/port_status_enc.sv
module port_status_enc
  import selfid_pkg::*;
(
  input  phy_byte_t   port_reg_i,
  input  logic        present_i,
  output logic [1:0]  code_o
);
  always_comb begin
    if (!present_i)          code_o = 2'b00;
    else if (!port_reg_i[2]) code_o = 2'b01;
    else                     code_o = {1'b1, port_reg_i[3]};
  end
endmodule

// File: rtl/selfid_pack.sv
module selfid_pack
  import selfid_pkg::*;
#(
  parameter int unsigned MAX_PORTS = 3
) (
  input  logic [PHY_ID_W-1:0] phy_id_i,
  input  phy_byte_t           regs_i [NUM_REGS],
  output logic [SID_W-1:0]    sid_o
);
  // port fields end at bit 2; a fourth would overlap the reset flag
  localparam int unsigned PORTS_USED = (MAX_PORTS > FIELD_PORTS_MAX) ? FIELD_PORTS_MAX : MAX_PORTS;

  logic [4:0] nports_raw, nports;
  logic [1:0] codes [PORTS_USED];
  logic       unused_reg_bits;

  assign nports_raw = regs_i[1][4:0];
  assign nports     = (nports_raw > 5'(PORTS_USED)) ? 5'(PORTS_USED) : nports_raw;
  assign unused_reg_bits = ^{regs_i[0], regs_i[1], regs_i[2], regs_i[3], regs_i[4], regs_i[5]};

  for (genvar p = 0; p < PORTS_USED; p++) begin : g_port
    port_status_enc u_enc (
      .port_reg_i (regs_i[2+p]),
      .present_i  (5'(p) < nports),
      .code_o     (codes[p])
    );
  end

  always_comb begin
    sid_o        = SID_BASE;
    sid_o[29:24] = phy_id_i;
    sid_o[21:16] = regs_i[0][5:0];
    sid_o[15:14] = regs_i[1][7:6];
    sid_o[11]    = regs_i[5][0];
    sid_o[1]     = regs_i[5][4];
    for (int p = 0; p < PORTS_USED; p++) begin
      sid_o[7-2*p -: 2] = codes[p];
    end
  end
endmodule

// File: rtl/own_selfid_gen.sv
module own_selfid_gen
  import selfid_pkg::*;
#(
  parameter int unsigned MAX_POLLS = 16,
  parameter int unsigned MAX_PORTS = 3
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [5:0]  phy_id_i,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic [31:0] selfid_o,
  output logic        phy_rd_o,
  output logic [3:0]  phy_addr_o,
  input  logic [31:0] phy_status_i
);
  logic                cap_en, build;
  logic [IDX_W-1:0]    cap_idx;
  phy_byte_t           cap_data;
  phy_byte_t           reg_q [NUM_REGS];
  logic [PHY_ID_W-1:0] phy_id_q;
  logic [SID_W-1:0]    sid_next, sid_q;

  phy_read_seq #(.MAX_POLLS(MAX_POLLS)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .phy_status_i (phy_status_i),
    .phy_rd_o     (phy_rd_o),
    .phy_addr_o   (phy_addr_o),
    .cap_en_o     (cap_en),
    .cap_idx_o    (cap_idx),
    .cap_data_o   (cap_data),
    .build_o      (build),
    .done_o       (done_o),
    .err_o        (err_o),
    .busy_o       (busy_o)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  reg_q[g] <= '0;
      else if (cap_en && (cap_idx == IDX_W'(g)))    reg_q[g] <= cap_data;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  phy_id_q <= '0;
    else if (start_i && !busy_o)  phy_id_q <= phy_id_i;
  end

  selfid_pack #(.MAX_PORTS(MAX_PORTS)) u_pack (
    .phy_id_i (phy_id_q),
    .regs_i   (reg_q),
    .sid_o    (sid_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sid_q <= '0;
    else if (build) sid_q <= sid_next;
  end

  assign selfid_o = sid_q;
endmodule

// File: rtl/own_selfid_gen_chk.sv
module own_selfid_gen_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o,
  input logic [31:0] selfid_o,
  input logic        phy_rd_o,
  input logic [3:0]  phy_addr_o
);
  AST_RD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_rd_o |=> !phy_rd_o); // R2
  AST_RD_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_rd_o |-> (phy_addr_o >= 4'd1 && phy_addr_o <= 4'd6)); // R2
  AST_FIRST_RD_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (phy_rd_o && phy_addr_o == 4'd1)); // R2
  AST_ERR_ONLY_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o); // R4
  AST_SID_KEPT_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> $stable(selfid_o)); // R4
  AST_SID_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (selfid_o[31:30] == 2'b10 && selfid_o[23:22] == 2'b01)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_SID_STABLE_OFF_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(selfid_o)); // R10
  AST_NO_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !phy_rd_o); // R10
endmodule

bind own_selfid_gen own_selfid_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .selfid_o   (selfid_o),
  .phy_rd_o   (phy_rd_o),
  .phy_addr_o (phy_addr_o)
);

// File: tb/own_selfid_gen_bench.sv
module own_selfid_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_POLLS  = 16;
  localparam int WATCHDOG   = 150000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  phy_id_i = '0;
  logic        busy_o, done_o, err_o, phy_rd_o;
  logic [31:0] selfid_o;
  logic [3:0]  phy_addr_o;
  logic [31:0] phy_status_i;

  int tests = 0;
  int fails = 0;
  bit chk_on = 1'b0;

  own_selfid_gen #(.MAX_POLLS(MAX_POLLS), .MAX_PORTS(3)) u_own_selfid_gen (
    .clk_i, .rst_ni, .start_i, .phy_id_i, .busy_o, .done_o, .err_o,
    .selfid_o, .phy_rd_o, .phy_addr_o, .phy_status_i
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // PHY model
  logic [7:0] cfg_reg [1:6];
  int         cfg_lat [1:6];
  logic [3:0] addr_log [$];
  bit         pend;
  int         pcnt;
  logic [3:0] paddr;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phy_status_i <= '0;
      pend <= 1'b0;
      pcnt <= 0;
      paddr <= '0;
    end else if (phy_rd_o) begin
      addr_log.push_back(phy_addr_o);
      pend  <= 1'b1;
      pcnt  <= cfg_lat[int'(phy_addr_o)];
      paddr <= phy_addr_o;
      phy_status_i <= {4'h0, phy_addr_o ^ 4'h8, 8'h5A, 16'h0};
    end else if (pend) begin
      if (pcnt == 0) begin
        phy_status_i <= {4'h0, paddr, cfg_reg[int'(paddr)], 16'h0};
        pend <= 1'b0;
      end else begin
        pcnt <= pcnt - 1;
        phy_status_i <= {4'hF, paddr ^ 4'h8, 8'hA5, 16'hFFFF};
      end
    end
  end

  // cycle-count reference model
  bit          m_busy = 1'b0, m_done = 1'b0;
  int          m_cnt = 0, plan_len = 0;
  bit          exp_err = 1'b0;
  logic [31:0] exp_sid = '0, last_sid = '0;
  string       cur_req = "R10";

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_cnt <= 0;
    end else if (!m_busy) begin
      if (start_i) begin m_busy <= 1'b1; m_cnt <= plan_len; end
    end else if (m_done) begin
      m_done <= 1'b0; m_busy <= 1'b0;
    end else if (m_cnt == 1) begin
      m_done <= 1'b1; m_cnt <= 0;
    end else begin
      m_cnt <= m_cnt - 1;
    end
  end

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && chk_on) begin
      check("R10", "busy_o", 32'(busy_o), 32'(m_busy));
      check("R10", "done_o", 32'(done_o), 32'(m_done));
      if (m_done) begin
        check("R4", "err_o", 32'(err_o), 32'(exp_err));
        check(cur_req, "selfid_o", selfid_o, exp_sid);
      end
    end
  end

  function automatic logic [31:0] calc_sid(input logic [5:0] pid);
    logic [31:0] w;
    int n;
    logic [1:0] code;
    w = 32'h8040_0000 | (32'(pid) << 24);
    w |= 32'(cfg_reg[1] & 8'h3F) << 16;
    w |= 32'(cfg_reg[2] >> 6) << 14;
    if (cfg_reg[6][0]) w |= 32'h800;
    if (cfg_reg[6][4]) w |= 32'h2;
    n = int'(cfg_reg[2] & 8'h1F);
    if (n > 3) n = 3;
    for (int p = 0; p < n; p++) begin
      if (cfg_reg[3+p][2] == 1'b0) code = 2'b01;
      else if (cfg_reg[3+p][3])    code = 2'b11;
      else                         code = 2'b10;
      w |= 32'(code) << (6 - 2*p);
    end
    return w;
  endfunction

  task automatic set_regs(input logic [7:0] a1, a2, a3, a4, a5, a6);
    cfg_reg[1] = a1; cfg_reg[2] = a2; cfg_reg[3] = a3;
    cfg_reg[4] = a4; cfg_reg[5] = a5; cfg_reg[6] = a6;
  endtask

  task automatic set_lat(input int l1, l2, l3, l4, l5, l6);
    cfg_lat[1] = l1; cfg_lat[2] = l2; cfg_lat[3] = l3;
    cfg_lat[4] = l4; cfg_lat[5] = l5; cfg_lat[6] = l6;
  endtask

  task automatic run_case(input string req, input logic [5:0] pid, input bit poke);
    int n_reads = 0;
    int len = 0;
    bit e = 1'b0;
    for (int r = 1; r <= 6; r++) begin
      n_reads++;
      if (cfg_lat[r] + 2 > MAX_POLLS) begin
        len += 1 + MAX_POLLS; e = 1'b1; break;
      end
      len += 3 + cfg_lat[r];
    end
    if (!e) len += 1;
    plan_len = len;
    exp_err  = e;
    exp_sid  = e ? last_sid : calc_sid(pid);
    cur_req  = req;
    addr_log.delete();
    @(negedge clk_i);
    phy_id_i = pid;
    start_i  = 1'b1;
    @(negedge clk_i);
    start_i  = 1'b0;
    if (poke) begin
      // R10: start and a new ID while busy must have no effect
      repeat (3) @(negedge clk_i);
      phy_id_i = ~pid;
      start_i  = 1'b1;
      @(negedge clk_i);
      start_i  = 1'b0;
    end
    for (int k = 0; k < 2000 && m_busy; k++) @(negedge clk_i);
    check("R2", "read count", 32'(addr_log.size()), 32'(n_reads));
    for (int k = 0; k < addr_log.size(); k++)
      check("R2", "read address", 32'(addr_log[k]), 32'(k + 1));
    if (!e) last_sid = exp_sid;
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    set_regs(8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    set_lat(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk_i);
    // R1 during reset
    check("R1", "busy_o in reset", 32'(busy_o), 32'd0);
    check("R1", "done_o in reset", 32'(done_o), 32'd0);
    check("R1", "phy_rd_o in reset", 32'(phy_rd_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "selfid_o after reset", selfid_o, 32'h0);
    check("R1", "err_o after reset", 32'(err_o), 32'd0);
    chk_on = 1'b1;

    // R6 R7 R8: three ports, all codes, both flags
    set_regs(8'h3F, 8'hC3, 8'h0C, 8'h04, 8'h00, 8'h11);
    run_case("R8", 6'd5, 1'b0);
    check("R8", "known quadlet", last_sid, 32'h857F_C8E6);

    // R3: varied latencies with distractor words; one port
    set_regs(8'hC5, 8'h41, 8'hF8, 8'hFF, 8'hFF, 8'hEE);
    set_lat(3, 0, 7, 1, 5, 2);
    run_case("R3", 6'h3F, 1'b0);

    // R9: port count 31 clamps to 3
    set_regs(8'h12, 8'h9F, 8'h04, 8'h0C, 8'h08, 8'h01);
    set_lat(0, 1, 0, 1, 0, 1);
    run_case("R9", 6'h2A, 1'b0);

    // R9: port count 0, all port fields 00
    set_regs(8'h21, 8'h80, 8'h0C, 8'h0C, 8'h0C, 8'h10);
    set_lat(0, 0, 0, 0, 0, 0);
    run_case("R9", 6'h01, 1'b0);

    // R4 boundary: match on the last permitted sample succeeds
    set_regs(8'h07, 8'h42, 8'h04, 8'h00, 8'h00, 8'h00);
    set_lat(MAX_POLLS - 2, 0, 0, MAX_POLLS - 2, 0, 0);
    run_case("R4", 6'h11, 1'b0);

    // R4: one sample too late on register 4 -> error, quadlet kept
    set_regs(8'h3A, 8'hC3, 8'h0C, 8'h0C, 8'h0C, 8'h11);
    set_lat(0, 0, 0, MAX_POLLS - 1, 0, 0);
    run_case("R4", 6'h22, 1'b0);
    check("R4", "quadlet held after error", selfid_o, last_sid);

    // R4: PHY never answers register 1
    set_lat(1000, 0, 0, 0, 0, 0);
    run_case("R4", 6'h33, 1'b0);

    // R5 R10: start and ID change while busy ignored
    set_regs(8'h15, 8'h42, 8'h08, 8'h0C, 8'h00, 8'h10);
    set_lat(2, 2, 2, 2, 2, 2);
    run_case("R5", 6'h0B, 1'b1);
    check("R5", "captured phy id", 32'(last_sid[29:24]), 32'h0B);

    // R6: another gap/speed pair after a failed run
    set_regs(8'h2B, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00);
    set_lat(0, 0, 0, 0, 0, 0);
    run_case("R6", 6'h00, 1'b0);
    check("R6", "gap and speed bits", last_sid & 32'h003F_C000, 32'h002B_4000);

    chk_on = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    fails++;
    tests++;
    $display("FAIL R10 watchdog: actual hung expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule